// File: doc/BRIEF.md
# Flag Offset Register Loader

This block sets the two threshold offsets that a FIFO's programmable flags compare against. One is the almost-empty offset (X) and one is the almost-full offset (Y). A synchronous master reset chooses how the two offsets are filled. The choice comes from a mode pin and two select pins, all sampled while reset is high. There are three ways to fill them:

- **Preset:** one of three fixed values is loaded into both offsets.
- **Parallel:** two words are written through the 36-bit write data port, Y first and then X.
- **Serial:** 40 bits are shifted in through the two select pins once reset has ended. One pin becomes an active-low shift enable and the other becomes the serial data line.

A done output tells the flag logic that both offsets hold their final values. After done, the offsets stay frozen until the next master reset. The FIFO storage and the flag comparators sit outside this block.

Top module: `flag_offset_loader`

## Requirements
- R1: On the first cycle after reset is released in serial or parallel method, both offsets read 0 and done is low.
- R2: With the mode pin high at reset, the select codes {hi,lo} choose a preset: 00 gives 8, 01 gives 16 and 10 gives 64. From the first cycle after release, both X and Y equal that value and done is high.
- R3: In preset method, write strobes and serial pin activity leave X, Y and done unchanged.
- R4: In parallel method (mode pin high, select code 11), the first clock edge with the write enable high loads Y from write data bits 19:0. Bits 35:20 are discarded and X keeps its value.
- R5: In parallel method, the second qualifying write loads X from write data bits 19:0. Done rises on that same edge.
- R6: In serial method (mode pin low at reset), each edge with the serial enable (the hi select pin) low shifts the concatenation {Y,X} left by one. The serial data (the lo select pin) enters at X bit 0. An edge with the enable high leaves both offsets unchanged.
- R7: In serial method, done rises on the edge that takes the 40th bit. At that point the first bit sits in Y bit 19 and the last bit sits in X bit 0.
- R8: Once done is high, further writes or serial bits change neither offset, and done stays high until the next reset.
- R9: The method is fixed by the pin levels at reset. After release, serial pin activity has no effect in parallel method, and the write enable has no effect in serial method.
- R10: A reset in the middle of programming discards any partial progress and picks a method anew from the pins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Write-side clock |
| rst | input | 1 | Synchronous active-high master reset |
| preset_mode_i | input | 1 | Method mode pin, sampled during reset |
| sel_hi_sen_n_i | input | 1 | Select bit 1 during reset; active-low serial enable afterwards |
| sel_lo_sdi_i | input | 1 | Select bit 0 during reset; serial data afterwards |
| wr_en_i | input | 1 | Write strobe for parallel loading |
| wr_data_i | input | 36 | Write data port |
| ofs_x_o | output | 20 | Almost-empty offset |
| ofs_y_o | output | 20 | Almost-full offset |
| done_o | output | 1 | Both offsets hold their final values |

## Verification
Both offsets are visible at the ports on every cycle, so a wrong internal state shows up on the edge where it occurs:

- **Wrong method latch:** a preset value appears, or expected shifting is missing, on the first cycle after reset.
- **Wrong shift direction or slot order:** a partial {Y,X} pattern with misplaced bits is visible after only a few serial bits.
- **Off-by-one bit or word counter:** done appears one edge early or late, beside offsets that are one bit short or one bit past the expected pattern.
- **Missing freeze after done:** the offsets move on the very next write or bit.

// File: rtl/flo_pkg.sv
package flo_pkg;

    localparam int OFS_W  = 20;
    localparam int DATA_W = 36;

    typedef enum logic [1:0] {
        M_SERIAL   = 2'd0,
        M_PARALLEL = 2'd1,
        M_PRESET   = 2'd2
    } method_e;

    typedef struct packed {
        method_e          method;
        logic [OFS_W-1:0] preset;
    } method_cfg_t;

    function automatic method_cfg_t decode_method(input logic mode,
                                                  input logic hi,
                                                  input logic lo);
        method_cfg_t c;
        c.preset = '0;
        if (!mode) begin
            c.method = M_SERIAL;
        end else begin
            unique case ({hi, lo})
                2'b00:   begin c.method = M_PRESET; c.preset = OFS_W'(8);  end
                2'b01:   begin c.method = M_PRESET; c.preset = OFS_W'(16); end
                2'b10:   begin c.method = M_PRESET; c.preset = OFS_W'(64); end
                default: c.method = M_PARALLEL;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/flo_method_latch.sv
module flo_method_latch
    import flo_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        mode_i,
    input  logic        hi_i,
    input  logic        lo_i,
    output method_cfg_t cfg_o
);
    method_cfg_t cfg_q;

    // Tracks the pins for as long as reset is held; frozen afterwards.
    always_ff @(posedge clk) begin
        if (rst) cfg_q <= decode_method(mode_i, hi_i, lo_i);
    end

    assign cfg_o = cfg_q;
endmodule

// File: rtl/flo_serial_shift.sv
module flo_serial_shift #(
    parameter int OFS_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic             sen_n_i,
    input  logic             sdi_i,
    output logic [OFS_W-1:0] x_o,
    output logic [OFS_W-1:0] y_o,
    output logic             done_o
);
    localparam int SER_BITS = 2 * OFS_W;
    localparam int CNT_W    = $clog2(SER_BITS + 1);

    logic [SER_BITS-1:0] chain_q;
    logic [CNT_W-1:0]    cnt_q;
    logic                done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
            cnt_q   <= '0;
            done_q  <= 1'b0;
        end else if (en_i && !sen_n_i && !done_q) begin
            chain_q <= {chain_q[SER_BITS-2:0], sdi_i};
            cnt_q   <= cnt_q + 1'b1;
            if (cnt_q == CNT_W'(SER_BITS - 1)) done_q <= 1'b1;
        end
    end

    assign y_o    = chain_q[SER_BITS-1:OFS_W];
    assign x_o    = chain_q[OFS_W-1:0];
    assign done_o = done_q;
endmodule

// File: rtl/flo_parallel_load.sv
module flo_parallel_load #(
    parameter int OFS_W  = 20,
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [OFS_W-1:0]  x_o,
    output logic [OFS_W-1:0]  y_o,
    output logic              done_o
);
    logic [OFS_W-1:0] x_q, y_q;
    logic             have_y_q, done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            x_q      <= '0;
            y_q      <= '0;
            have_y_q <= 1'b0;
            done_q   <= 1'b0;
        end else if (en_i && wr_en_i && !done_q) begin
            if (!have_y_q) begin
                y_q      <= wr_data_i[OFS_W-1:0];
                have_y_q <= 1'b1;
            end else begin
                x_q    <= wr_data_i[OFS_W-1:0];
                done_q <= 1'b1;
            end
        end
    end

    assign x_o    = x_q;
    assign y_o    = y_q;
    assign done_o = done_q;
endmodule

// File: rtl/flag_offset_loader.sv
module flag_offset_loader
    import flo_pkg::*;
#(
    parameter int P_OFS_W  = OFS_W,
    parameter int P_DATA_W = DATA_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                preset_mode_i,
    input  logic                sel_hi_sen_n_i,
    input  logic                sel_lo_sdi_i,
    input  logic                wr_en_i,
    input  logic [P_DATA_W-1:0] wr_data_i,
    output logic [P_OFS_W-1:0]  ofs_x_o,
    output logic [P_OFS_W-1:0]  ofs_y_o,
    output logic                done_o
);
    method_cfg_t      cfg;
    method_e          method_q;
    logic [P_OFS_W-1:0] ser_x, ser_y, par_x, par_y;
    logic             ser_done, par_done;

    flo_method_latch u_latch (
        .clk    (clk),
        .rst    (rst),
        .mode_i (preset_mode_i),
        .hi_i   (sel_hi_sen_n_i),
        .lo_i   (sel_lo_sdi_i),
        .cfg_o  (cfg)
    );

    assign method_q = cfg.method;

    flo_serial_shift #(.OFS_W(P_OFS_W)) u_ser (
        .clk     (clk),
        .rst     (rst),
        .en_i    (method_q == M_SERIAL),
        .sen_n_i (sel_hi_sen_n_i),
        .sdi_i   (sel_lo_sdi_i),
        .x_o     (ser_x),
        .y_o     (ser_y),
        .done_o  (ser_done)
    );

    flo_parallel_load #(.OFS_W(P_OFS_W), .DATA_W(P_DATA_W)) u_par (
        .clk       (clk),
        .rst       (rst),
        .en_i      (method_q == M_PARALLEL),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .x_o       (par_x),
        .y_o       (par_y),
        .done_o    (par_done)
    );

    always_comb begin
        unique case (method_q)
            M_SERIAL:   begin ofs_x_o = ser_x; ofs_y_o = ser_y; done_o = ser_done; end
            M_PARALLEL: begin ofs_x_o = par_x; ofs_y_o = par_y; done_o = par_done; end
            default:    begin
                ofs_x_o = P_OFS_W'(cfg.preset);
                ofs_y_o = P_OFS_W'(cfg.preset);
                done_o  = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/flo_checker.sv
module flo_checker
    import flo_pkg::*;
#(
    parameter int P_OFS_W = OFS_W
) (
    input logic               clk,
    input logic               rst,
    input logic               sen_n,
    input logic               sdi,
    input method_e            method,
    input logic [P_OFS_W-1:0] x,
    input logic [P_OFS_W-1:0] y,
    input logic               done
);
    // R8: done holds until reset
    p_done_hold_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    // R8: offsets frozen after done
    p_frozen_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> ($stable(x) && $stable(y)));

    // R6: one serial bit enters X LSB, X MSB moves into Y LSB
    p_shift_r6: assert property (@(posedge clk) disable iff (rst)
        (method == M_SERIAL && !sen_n && !done) |=>
        (x[0] == $past(sdi) && y[0] == $past(x[P_OFS_W-1])));

    // R6: idle serial enable holds the offsets
    p_idle_r6: assert property (@(posedge clk) disable iff (rst)
        (method == M_SERIAL && sen_n) |=> ($stable(x) && $stable(y)));

    // R2: preset fills both offsets equally with done high
    p_preset_r2: assert property (@(posedge clk) disable iff (rst)
        (method == M_PRESET) |-> (done && x == y));

    // R1: cleared state right after release in programmed methods
    p_reset_r1: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && method != M_PRESET) |-> (x == '0 && y == '0 && !done));
endmodule

bind flag_offset_loader flo_checker #(.P_OFS_W(P_OFS_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .sen_n  (sel_hi_sen_n_i),
    .sdi    (sel_lo_sdi_i),
    .method (method_q),
    .x      (ofs_x_o),
    .y      (ofs_y_o),
    .done   (done_o)
);

// File: tb/sim_flag_offset_loader.sv
module sim_flag_offset_loader;
    localparam int CLK_PERIOD = 10;
    localparam int OW = 20;
    localparam int DW = 36;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          mode = 1'b0, hi = 1'b1, lo = 1'b0, wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [OW-1:0] x, y;
    logic          done;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flag_offset_loader u0 (
        .clk(clk), .rst(rst), .preset_mode_i(mode),
        .sel_hi_sen_n_i(hi), .sel_lo_sdi_i(lo),
        .wr_en_i(wr_en), .wr_data_i(wr_data),
        .ofs_x_o(x), .ofs_y_o(y), .done_o(done)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req, input logic [OW-1:0] ex,
                             input logic [OW-1:0] ey, input logic ed);
        check({req, " x"}, 64'(x), 64'(ex));
        check({req, " y"}, 64'(y), 64'(ey));
        check({req, " done"}, 64'(done), 64'(ed));
    endtask

    task automatic do_reset(input logic m, input logic h, input logic l);
        @(negedge clk);
        rst = 1'b1; mode = m; hi = h; lo = l; wr_en = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0; hi = 1'b1; lo = 1'b0;
    endtask

    task automatic par_write(input logic [DW-1:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ser_bit(input logic b);
        hi = 1'b0; lo = b;
        @(negedge clk);
        hi = 1'b1;
    endtask

    task automatic t_preset();
        do_reset(1'b1, 1'b0, 1'b0);
        check_all("R2 preset8", 20'd8, 20'd8, 1'b1);
        do_reset(1'b1, 1'b0, 1'b1);
        check_all("R2 preset16", 20'd16, 20'd16, 1'b1);
        do_reset(1'b1, 1'b1, 1'b0);
        check_all("R2 preset64", 20'd64, 20'd64, 1'b1);
        par_write(36'h0_000F_FFFF);
        ser_bit(1'b1);
        ser_bit(1'b1);
        check_all("R3 preset ignores writes", 20'd64, 20'd64, 1'b1);
    endtask

    task automatic t_parallel();
        do_reset(1'b1, 1'b1, 1'b1);
        check_all("R1 parallel reset", '0, '0, 1'b0);
        ser_bit(1'b1); ser_bit(1'b1);
        check_all("R9 serial pins ignored in parallel", '0, '0, 1'b0);
        par_write(36'hF_FFF1_2345);
        check_all("R4 first write to Y", '0, 20'h12345, 1'b0);
        @(negedge clk);
        check_all("R4 idle holds", '0, 20'h12345, 1'b0);
        par_write(36'hA_BCDA_BCDE);
        check_all("R5 second write to X", 20'hABCDE, 20'h12345, 1'b1);
        par_write(36'h0_0000_0777);
        check_all("R8 parallel frozen", 20'hABCDE, 20'h12345, 1'b1);
    endtask

    task automatic t_serial();
        logic [2*OW-1:0] pat = {20'hA5C3F, 20'h0F0F1};
        logic [2*OW-1:0] part;
        do_reset(1'b0, 1'b1, 1'b0);
        check_all("R1 serial reset", '0, '0, 1'b0);
        par_write(36'h0_000F_FFFF);
        check_all("R9 write ignored in serial", '0, '0, 1'b0);
        for (int i = 2*OW-1; i >= 2*OW-10; i--) ser_bit(pat[i]);
        part = pat >> 30;
        check_all("R6 partial 10 bits", part[OW-1:0], part[2*OW-1:OW], 1'b0);
        hi = 1'b1; lo = 1'b1;
        repeat (2) @(negedge clk);
        lo = 1'b0;
        check_all("R6 enable high holds", part[OW-1:0], part[2*OW-1:OW], 1'b0);
        for (int i = 2*OW-11; i >= 1; i--) ser_bit(pat[i]);
        part = pat >> 1;
        check_all("R7 39 bits no done", part[OW-1:0], part[2*OW-1:OW], 1'b0);
        ser_bit(pat[0]);
        check_all("R7 40 bits done", pat[OW-1:0], pat[2*OW-1:OW], 1'b1);
        ser_bit(1'b0); ser_bit(1'b1);
        check_all("R8 serial frozen", pat[OW-1:0], pat[2*OW-1:OW], 1'b1);
    endtask

    task automatic t_midreset();
        do_reset(1'b0, 1'b1, 1'b0);
        for (int i = 0; i < 5; i++) ser_bit(1'b1);
        check_all("R10 partial serial", 20'h1F, '0, 1'b0);
        do_reset(1'b1, 1'b1, 1'b1);
        check_all("R10 reset clears", '0, '0, 1'b0);
        par_write(36'h0_0000_0055);
        check_all("R10 new method parallel", '0, 20'h55, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_preset();
        t_parallel();
        t_serial();
        t_midreset();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule